// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block guards one 36-bit data port that is split into four 9-bit lanes. Each lane carries eight data bits and one parity bit in its top position. Data arriving on the port is checked without being altered. An active-low error output drops whenever a lane that is marked as in use carries the wrong parity. A single select chooses odd or even parity, and that choice governs both checking and generation.

On the read side, the block registers the word handed to it by the storage logic. When generation is enabled, it overwrites each lane's top bit with freshly computed parity. Reads from the mailbox path and reads from the queue path both produce parity. The mailbox path borrows the same parity trees that the checker uses. While such a mailbox read with generation is set up, the checker's result has no meaning, so the error output is held inactive. A lane-valid mask lets a narrower bus size restrict checking to the lanes it actually drives: all four lanes for 36 bits, two for 18 bits, one for 9 bits.

Top module: `bpar_port`

## Requirements
- R1: Lane k occupies bits 9k to 9k+8, and bit 9k+8 is that lane's parity bit; lanes are checked and generated independently.
- R2: With `odd_sel` high, a lane passes when its nine bits hold an odd number of ones. With `odd_sel` low, it passes when they hold an even number of ones.
- R3: Outside mailbox generation mode, `perr_n` is combinational and is low exactly when at least one lane with its `lane_valid` bit set fails parity on `bus_in`.
- R4: A lane whose `lane_valid` bit is clear has no effect on `perr_n`, whatever its contents; with the mask at zero, `perr_n` is high.
- R5: On a clock edge with `rd_sel` and `gen_en` high, `bus_out` takes `rd_data` with each lane's parity bit replaced by the XOR of its eight data bits, inverted when `odd_sel` is high. This holds for both `mbox_sel` values.
- R6: On a clock edge with `rd_sel` high and `gen_en` low, `bus_out` takes `rd_data` unchanged.
- R7: On a clock edge with `rd_sel` low, `bus_out` keeps its value.
- R8: While `rd_sel`, `mbox_sel` and `gen_en` are all high, `perr_n` is high regardless of `bus_in` and `lane_valid`.
- R9: A clock edge with `rst` high clears `bus_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| lane_valid | input | 4 | Lanes taking part in the check, bit k for lane k |
| bus_in | input | 36 | Word applied to the port (checked) |
| perr_n | output | 1 | Low when a valid lane fails parity |
| rd_sel | input | 1 | Read cycle: load the output register |
| mbox_sel | input | 1 | Read comes from the mailbox path (shared trees) |
| gen_en | input | 1 | Replace parity bits on read data |
| rd_data | input | 36 | Word supplied by storage for a read |
| bus_out | output | 36 | Registered read word |

## Verification
The assertions assume that `rst` is driven high from time zero. They also assume that the mode inputs are stable around each rising edge, so a `$past` value seen after an edge is the value captured at that edge. The bench changes every input only on falling edges. It holds reset for several cycles before releasing it, and it samples outputs on the next falling edge, half a period after the edge that loads `bus_out`.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

  // What the output register does on the coming edge
  typedef enum logic [1:0] {
    RD_HOLD   = 2'd0,
    RD_PASS   = 2'd1,
    RD_GEN_Q  = 2'd2,
    RD_GEN_MB = 2'd3
  } rd_mode_e;

endpackage

// File: rtl/bpar_tree.sv
module bpar_tree #(
  parameter int LANES  = 4,
  parameter int DATA_W = 8
) (
  input  logic [LANES*DATA_W-1:0] body,
  input  logic                    odd_sel,
  output logic [LANES-1:0]        par
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign par[k] = (^body[k*DATA_W +: DATA_W]) ^ odd_sel;
  end

endmodule

// File: rtl/bpar_check.sv
module bpar_check #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] tops,
  input  logic [LANES-1:0] par,
  input  logic [LANES-1:0] lane_valid,
  input  logic             force_ok,
  output logic             err_n
);

  logic [LANES-1:0] bad;

  for (genvar k = 0; k < LANES; k++) begin : g_cmp
    assign bad[k] = (tops[k] ^ par[k]) & lane_valid[k];
  end

  assign err_n = force_ok | ~(|bad);

endmodule

// File: rtl/bpar_gen.sv
module bpar_gen #(
  parameter int LANES  = 4,
  parameter int DATA_W = 8,
  localparam int LW    = DATA_W + 1
) (
  input  logic [LANES*DATA_W-1:0] body,
  input  logic [LANES-1:0]        par,
  output logic [LANES*LW-1:0]     word
);

  for (genvar k = 0; k < LANES; k++) begin : g_pack
    assign word[k*LW +: LW] = {par[k], body[k*DATA_W +: DATA_W]};
  end

endmodule

// File: rtl/bpar_port.sv
module bpar_port
  import bpar_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANE_W - 1,
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             odd_sel,
  input  logic [LANES-1:0] lane_valid,
  input  logic [W-1:0]     bus_in,
  output logic             perr_n,
  input  logic             rd_sel,
  input  logic             mbox_sel,
  input  logic             gen_en,
  input  logic [W-1:0]     rd_data,
  output logic [W-1:0]     bus_out
);

  rd_mode_e mode;

  logic [LANES*DW-1:0] in_body, rd_body, tree_body;
  logic [LANES-1:0]    in_tops;
  logic [LANES-1:0]    shared_par, q_par;
  logic [W-1:0]        mb_word, q_word;
  logic                shared;

  // split both words into data bodies and parity tops
  for (genvar k = 0; k < LANES; k++) begin : g_split
    assign in_body[k*DW +: DW] = bus_in[k*LANE_W +: DW];
    assign in_tops[k]          = bus_in[k*LANE_W + DW];
    assign rd_body[k*DW +: DW] = rd_data[k*LANE_W +: DW];
  end

  always_comb begin
    if (!rd_sel)       mode = RD_HOLD;
    else if (!gen_en)  mode = RD_PASS;
    else if (mbox_sel) mode = RD_GEN_MB;
    else               mode = RD_GEN_Q;
  end

  assign shared    = (mode == RD_GEN_MB);
  assign tree_body = shared ? rd_body : in_body;

  // trees shared by checking and mailbox generation
  bpar_tree #(.LANES(LANES), .DATA_W(DW)) u_shared_tree (
    .body    (tree_body),
    .odd_sel (odd_sel),
    .par     (shared_par)
  );

  // dedicated trees for queue-path generation
  bpar_tree #(.LANES(LANES), .DATA_W(DW)) u_q_tree (
    .body    (rd_body),
    .odd_sel (odd_sel),
    .par     (q_par)
  );

  bpar_check #(.LANES(LANES)) u_check (
    .tops       (in_tops),
    .par        (shared_par),
    .lane_valid (lane_valid),
    .force_ok   (shared),
    .err_n      (perr_n)
  );

  bpar_gen #(.LANES(LANES), .DATA_W(DW)) u_gen_mb (
    .body (rd_body),
    .par  (shared_par),
    .word (mb_word)
  );

  bpar_gen #(.LANES(LANES), .DATA_W(DW)) u_gen_q (
    .body (rd_body),
    .par  (q_par),
    .word (q_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
    end else begin
      case (mode)
        RD_PASS:   bus_out <= rd_data;
        RD_GEN_Q:  bus_out <= q_word;
        RD_GEN_MB: bus_out <= mb_word;
        default:   bus_out <= bus_out;
      endcase
    end
  end

endmodule

// File: rtl/bpar_port_chk.sv
module bpar_port_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANE_W - 1,
  localparam int W     = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             odd_sel,
  input logic [LANES-1:0] lane_valid,
  input logic             perr_n,
  input logic             rd_sel,
  input logic             mbox_sel,
  input logic             gen_en,
  input logic [W-1:0]     rd_data,
  input logic [W-1:0]     bus_out
);

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (bus_out == '0));

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_sel |=> $stable(bus_out));

  a_r6_raw_copy: assert property (@(posedge clk) disable iff (rst)
    (rd_sel && !gen_en) |=> (bus_out == $past(rd_data)));

  a_r8_forced_high: assert property (@(posedge clk) disable iff (rst)
    (rd_sel && mbox_sel && gen_en) |-> perr_n);

  a_r4_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (lane_valid == '0) |-> perr_n);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // R5 and R2: generated lane has the selected parity, data bits kept
    a_r5_lane_parity: assert property (@(posedge clk) disable iff (rst)
      (rd_sel && gen_en) |=> ((^bus_out[k*LANE_W +: LANE_W]) == $past(odd_sel)));
    a_r5_lane_body: assert property (@(posedge clk) disable iff (rst)
      (rd_sel && gen_en) |=>
        (bus_out[k*LANE_W +: DW] == $past(rd_data[k*LANE_W +: DW])));
  end

endmodule

bind bpar_port bpar_port_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .odd_sel    (odd_sel),
  .lane_valid (lane_valid),
  .perr_n     (perr_n),
  .rd_sel     (rd_sel),
  .mbox_sel   (mbox_sel),
  .gen_en     (gen_en),
  .rd_data    (rd_data),
  .bus_out    (bus_out)
);

// File: tb/bpar_port_bench.sv
module bpar_port_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        odd_sel = 1'b0;
  logic [3:0]  lane_valid = 4'h0;
  logic [35:0] bus_in = '0;
  logic        perr_n;
  logic        rd_sel = 1'b0;
  logic        mbox_sel = 1'b0;
  logic        gen_en = 1'b0;
  logic [35:0] rd_data = '0;
  logic [35:0] bus_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  bpar_port u_bpar_port (
    .clk(clk), .rst(rst), .odd_sel(odd_sel), .lane_valid(lane_valid),
    .bus_in(bus_in), .perr_n(perr_n), .rd_sel(rd_sel), .mbox_sel(mbox_sel),
    .gen_en(gen_en), .rd_data(rd_data), .bus_out(bus_out)
  );

  // {odd_sel, lane_valid, lane3, lane2, lane1, lane0, expected perr_n}
  localparam logic [41:0] VEC [12] = '{
    {1'b0, 4'hF, 9'h000, 9'h101, 9'h0FF, 9'h000, 1'b1},
    {1'b1, 4'hF, 9'h000, 9'h101, 9'h0FF, 9'h000, 1'b0},
    {1'b1, 4'hF, 9'h001, 9'h100, 9'h1FF, 9'h001, 1'b1},
    {1'b0, 4'hF, 9'h001, 9'h100, 9'h1FF, 9'h001, 1'b0},
    {1'b0, 4'hF, 9'h000, 9'h000, 9'h000, 9'h001, 1'b0},
    {1'b0, 4'hE, 9'h000, 9'h000, 9'h000, 9'h001, 1'b1},
    {1'b0, 4'h8, 9'h001, 9'h000, 9'h000, 9'h000, 1'b0},
    {1'b0, 4'h7, 9'h001, 9'h000, 9'h000, 9'h000, 1'b1},
    {1'b1, 4'h0, 9'h000, 9'h000, 9'h000, 9'h000, 1'b1},
    {1'b1, 4'h3, 9'h000, 9'h000, 9'h001, 9'h001, 1'b1},
    {1'b1, 4'hC, 9'h000, 9'h001, 9'h001, 9'h001, 1'b0},
    {1'b0, 4'h2, 9'h0FF, 9'h0FF, 9'h101, 9'h0FF, 1'b1}
  };

  task automatic check(input string req, input logic [35:0] act,
                       input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected read word from the parity rule, counting ones per lane
  function automatic logic [35:0] gen_word(input logic [35:0] d, input logic odd);
    logic [35:0] r = d;
    for (int k = 0; k < 4; k++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += int'(d[k*9+b]);
      r[k*9+8] = ((ones % 2) == 1) ? ~odd : odd;
    end
    return r;
  endfunction

  task automatic do_read(input logic [35:0] d, input logic odd, input logic mb,
                         input logic gen, input string req);
    @(negedge clk);
    rd_data = d; odd_sel = odd; mbox_sel = mb; gen_en = gen; rd_sel = 1'b1;
    @(negedge clk);
    rd_sel = 1'b0;
    check(req, bus_out, gen ? gen_word(d, odd) : d);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", bus_out, 36'h0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R4
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      odd_sel = VEC[i][41];
      lane_valid = VEC[i][40:37];
      bus_in = VEC[i][36:1];
      #1 check("R3", {35'h0, perr_n}, {35'h0, VEC[i][0]});
    end

    // every single-bit error in every lane, even parity (R1 R3 R4)
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 9; b++) begin
        @(negedge clk);
        odd_sel = 1'b0;
        bus_in = 36'h0;
        bus_in[k*9+b] = 1'b1;
        lane_valid = 4'hF;
        #1 check("R1", {35'h0, perr_n}, 36'h0);
        lane_valid = ~(4'b1 << k);
        #1 check("R4", {35'h0, perr_n}, 36'h1);
      end
    end

    // R8: shared-tree mode forces the flag high
    @(negedge clk);
    odd_sel = 1'b0; lane_valid = 4'hF; bus_in = 36'h1;
    rd_sel = 1'b1; mbox_sel = 1'b1; gen_en = 1'b1;
    #1 check("R8", {35'h0, perr_n}, 36'h1);
    gen_en = 1'b0;
    #1 check("R8", {35'h0, perr_n}, 36'h0);
    gen_en = 1'b1; mbox_sel = 1'b0;
    #1 check("R8", {35'h0, perr_n}, 36'h0);
    rd_sel = 1'b0;

    // R5 generation on both paths, both parity senses
    do_read(36'h0_0000_0000, 1'b0, 1'b0, 1'b1, "R5");
    do_read(36'h0_0000_0000, 1'b1, 1'b0, 1'b1, "R5");
    do_read(36'hF_FFFF_FFFF, 1'b0, 1'b1, 1'b1, "R5");
    do_read(36'h1_2345_6789, 1'b1, 1'b1, 1'b1, "R5");
    do_read(36'h9_8765_4321, 1'b0, 1'b0, 1'b1, "R5");
    do_read(36'h5_A5A5_A5A5, 1'b1, 1'b0, 1'b1, "R5");
    // R6 unchanged copy
    do_read(36'hF_0F0F_0F0F, 1'b1, 1'b1, 1'b0, "R6");
    do_read(36'h1_0000_0001, 1'b0, 1'b0, 1'b0, "R6");

    // R7 hold when not reading
    @(negedge clk);
    rd_data = 36'hA_AAAA_AAAA; gen_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R7", bus_out, 36'h1_0000_0001);

    // R9 reset clears a loaded register
    rst = 1'b1;
    @(negedge clk);
    check("R9", bus_out, 36'h0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule